// File: doc/BRIEF.md
# SPI Slave Interface with Sticky Transmit Holding

This block is the target side of an SPI link. An external master drives the serial clock, an active-low select and the master-out data line. The block shifts received bits into a character and drives its own reply bits back to the master. The character length, the clock idle level and the capture phase come from three configuration inputs. All three serial inputs are brought into the system clock domain through synchroniser chains, and all shifting runs on edges found in that domain.

On the host side there is a receive holding word with a full flag and a sticky overrun flag, and a transmit holding word with an empty flag and a sticky underrun flag. There is also a status-read strobe that clears both sticky flags. The transmit path follows fixed rules. Until software writes anything, the shift register resends what it last received, and it holds all zeros after reset. The first write goes straight into the shift register. Later writes wait in the holding word and replace one another until the next character starts. A character that starts with no fresh write resends the old holding word and raises underrun.

Top module: `spi_slave_sticky`

## Requirements
- R1: After reset, rx_full, ovr_flag and und_flag are 0 and tx_empty is 1. The shift register is zero, so a character sent before any write or any reception carries all-zero bits on spi_miso.
- R2: While spi_nss is high, edges on spi_sck do not count as bits and do not set rx_full. The next selected character is received with correct bit alignment.
- R3: The character length is 8 + cfg_len bits for cfg_len values 0 to 8. Any larger cfg_len value gives 16 bits. Both lines carry the most significant bit first. rx_data holds the character in its low bits, with the unused upper bits at zero.
- R4: cfg_cpol gives the idle level of spi_sck. With cfg_ncpha = 1, data is captured on the leading edge (the edge leaving idle) and changed on the trailing edge. With cfg_ncpha = 0, data is changed on the leading edge and captured on the trailing edge. All four combinations transfer correctly.
- R5: When the last bit of a character is captured, rx_data takes the character and rx_full goes to 1. A one-cycle pulse on rx_re clears rx_full.
- R6: If a character completes while rx_full is 1, ovr_flag goes to 1 and rx_data still takes the new character. A pulse on stat_re clears both ovr_flag and und_flag.
- R7: If the transmit holding word has never been written, each character sends the previous received character.
- R8: The first write after reset goes straight into the shift register and tx_empty stays 1. That value goes out in the next character, and underrun is not raised.
- R9: A later write clears tx_empty and replaces any earlier unsent write. When the next character starts, the latest value is loaded and sent, and tx_empty returns to 1.
- R10: If a character starts with no write since the last load, the old holding value is sent again and und_flag goes to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 4 | Character length code (length = 8 + code, capped at 16) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_ncpha | input | 1 | 1: capture on leading edge; 0: capture on trailing edge |
| spi_sck | input | 1 | Serial clock from the master |
| spi_nss | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_we | input | 1 | Write strobe for the transmit holding word |
| tx_data | input | 16 | Transmit write data |
| tx_empty | output | 1 | Transmit holding word has been taken |
| rx_re | input | 1 | Read strobe for the receive word, clears rx_full |
| rx_data | output | 16 | Last received character |
| rx_full | output | 1 | Unread received character present |
| stat_re | input | 1 | Status read strobe, clears the sticky flags |
| ovr_flag | output | 1 | Sticky receive overrun |
| und_flag | output | 1 | Sticky transmit underrun |

## Verification
A master model in the bench runs characters in several transmit situations, and each one has a distinct expected reply. These are: before any write (all zeros), never written (echo of the last reception), first write (immediate load), two writes before a character (only the latest is sent), and no fresh write (stale resend with underrun). The same traffic is run in all four clock polarity and phase settings, with lengths of 8, 9, 12 and 16 and a length code above the cap. This separates capture-edge errors, bit-order errors and masking errors. Back-to-back unread characters check overrun against normal reception. Clock toggling with the select high shows whether the bit counter is gated by the select.

// File: rtl/spis_pkg.sv
package spis_pkg;

   // Per-cycle serial events decoded in the system clock domain.
   typedef struct packed {
      logic sel;     // select active (synchronised)
      logic sample;  // capture edge seen while selected
      logic change;  // output edge seen while selected
      logic din;     // synchronised master-out data
   } spis_strb_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int                 WIDTH     = 3,
   parameter int                 STAGES    = 2,
   parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RESET_VAL}};
      end else begin
         stg <= {stg[STAGES-2:0], d};
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_edge.sv
module spis_edge
   import spis_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_s,
   input  logic       nss_s,
   input  logic       mosi_s,
   input  logic       cpol,
   input  logic       ncpha,
   output spis_strb_t strb
);

   logic sck_d;
   logic rise, fall, lead, trail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
      end else begin
         sck_d <= sck_s;
      end
   end

   assign rise  = sck_s & ~sck_d;
   assign fall  = ~sck_s & sck_d;
   assign lead  = cpol ? fall : rise;
   assign trail = cpol ? rise : fall;

   always_comb begin
      strb.sel    = ~nss_s;
      strb.sample = ~nss_s & (ncpha ? lead  : trail);
      strb.change = ~nss_s & (ncpha ? trail : lead);
      strb.din    = mosi_s;
   end

endmodule

// File: rtl/spis_shifter.sv
module spis_shifter
   import spis_pkg::*;
#(
   parameter int MAX_BITS = 16,
   parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  spis_strb_t          strb,
   input  logic [CNT_W-1:0]    len,
   input  logic                base_tdr,
   input  logic [MAX_BITS-1:0] tdr_word,
   input  logic                imm_load,
   input  logic [MAX_BITS-1:0] imm_word,
   output logic                idle,
   output logic                start,
   output logic                done,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                miso
);

   localparam int IDX_W = $clog2(MAX_BITS);

   logic [MAX_BITS-1:0] sreg, base, nxt, lenmask;
   logic [CNT_W-1:0]    cnt;
   logic [IDX_W-1:0]    msb;
   logic                last, miso_q;

   assign idle    = (cnt == '0);
   assign msb     = IDX_W'(len - CNT_W'(1));
   assign last    = (cnt == len - CNT_W'(1));
   assign base    = (idle && base_tdr) ? tdr_word : sreg;
   assign nxt     = {base[MAX_BITS-2:0], strb.din};
   assign lenmask = ~({MAX_BITS{1'b1}} << len);
   assign start   = strb.sample & idle;
   assign done    = strb.sample & last;
   assign rx_word = nxt & lenmask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sreg <= '0;
      end else begin
         if (!strb.sel) begin
            cnt <= '0;
         end else if (strb.sample) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
         end
         if (strb.sample) begin
            sreg <= last ? rx_word : nxt;
         end else if (imm_load) begin
            sreg <= imm_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miso_q <= 1'b0;
      end else if (idle) begin
         miso_q <= base[msb];
      end else if (strb.change) begin
         miso_q <= sreg[msb];
      end
   end

   assign miso = miso_q;

endmodule

// File: rtl/spi_slave_sticky.sv
module spi_slave_sticky
   import spis_pkg::*;
#(
   parameter int MIN_BITS    = 8,
   parameter int MAX_BITS    = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(MAX_BITS - MIN_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic                cfg_cpol,
   input  logic                cfg_ncpha,
   input  logic                spi_sck,
   input  logic                spi_nss,
   input  logic                spi_mosi,
   output logic                spi_miso,
   input  logic                tx_we,
   input  logic [MAX_BITS-1:0] tx_data,
   output logic                tx_empty,
   input  logic                rx_re,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                rx_full,
   input  logic                stat_re,
   output logic                ovr_flag,
   output logic                und_flag
);

   localparam int CNT_W = $clog2(MAX_BITS + 1);
   localparam int SPAN  = MAX_BITS - MIN_BITS;

   generate
      if (MIN_BITS < 2 || MAX_BITS < MIN_BITS) begin : g_bad_len
         $error("spi_slave_sticky: need 2 <= MIN_BITS <= MAX_BITS");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_slave_sticky: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- character length decode ----------------
   logic [CNT_W-1:0] len;
   always_comb begin
      if (cfg_len > LEN_W'(SPAN)) begin
         len = CNT_W'(MAX_BITS);
      end else begin
         len = CNT_W'(MIN_BITS) + CNT_W'(cfg_len);
      end
   end

   // ---------------- input synchronisation ----------------
   logic [2:0] pins_s;
   spis_sync #(
      .WIDTH     (3),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_nss, spi_mosi}),
      .q     (pins_s)
   );

   spis_strb_t strb;
   spis_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_s  (pins_s[2]),
      .nss_s  (pins_s[1]),
      .mosi_s (pins_s[0]),
      .cpol   (cfg_cpol),
      .ncpha  (cfg_ncpha),
      .strb   (strb)
   );

   // ---------------- transmit holding state ----------------
   logic [MAX_BITS-1:0] tdr;
   logic                tx_written, tx_primed, tdre, und_q;
   logic                base_tdr, imm_load, sh_idle;
   logic                xfer_start, xfer_done, xfer_sel;
   logic [MAX_BITS-1:0] rx_word;

   // Next character comes from the holding word when it is fresh, or when
   // it is stale and the shift register no longer holds an unsent load.
   assign base_tdr = tx_written & (~tdre | ~tx_primed);
   assign imm_load = tx_we & ~tx_written & sh_idle & ~xfer_start;
   assign xfer_sel = strb.sel;

   spis_shifter #(
      .MAX_BITS (MAX_BITS),
      .CNT_W    (CNT_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .strb     (strb),
      .len      (len),
      .base_tdr (base_tdr),
      .tdr_word (tdr),
      .imm_load (imm_load),
      .imm_word (tx_data),
      .idle     (sh_idle),
      .start    (xfer_start),
      .done     (xfer_done),
      .rx_word  (rx_word),
      .miso     (spi_miso)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr        <= '0;
         tx_written <= 1'b0;
         tx_primed  <= 1'b0;
         tdre       <= 1'b1;
      end else begin
         if (xfer_start) begin
            tx_primed <= 1'b0;
            if (!tdre) begin
               tdre <= 1'b1;
            end
         end
         if (tx_we) begin
            tdr        <= tx_data;
            tx_written <= 1'b1;
            if (imm_load) begin
               tx_primed <= 1'b1;
            end else begin
               tdre <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         und_q <= 1'b0;
      end else if (xfer_start && tx_written && tdre && !tx_primed) begin
         und_q <= 1'b1;
      end else if (stat_re) begin
         und_q <= 1'b0;
      end
   end

   // ---------------- receive holding state ----------------
   logic [MAX_BITS-1:0] rdr;
   logic                rdrf, ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdr  <= '0;
         rdrf <= 1'b0;
      end else if (xfer_done) begin
         rdr  <= rx_word;
         rdrf <= 1'b1;
      end else if (rx_re) begin
         rdrf <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (xfer_done && rdrf) begin
         ovr_q <= 1'b1;
      end else if (stat_re) begin
         ovr_q <= 1'b0;
      end
   end

   assign tx_empty = tdre;
   assign rx_data  = rdr;
   assign rx_full  = rdrf;
   assign ovr_flag = ovr_q;
   assign und_flag = und_q;

endmodule

// File: rtl/spis_chk.sv
module spis_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_we,
   input logic rx_re,
   input logic stat_re,
   input logic tx_empty,
   input logic rx_full,
   input logic ovr_flag,
   input logic und_flag,
   input logic xfer_sel,
   input logic xfer_start
);

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(rx_full)) else $error("overrun without full"); // R6

   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !stat_re) |=> ovr_flag) else $error("overrun dropped"); // R6

   AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (und_flag && !stat_re) |=> und_flag) else $error("underrun dropped"); // R10

   AST_TDRE_FALL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(tx_we)) else $error("tx_empty fell w/o write"); // R9

   AST_LOAD_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && !tx_empty && !tx_we) |=> tx_empty) else $error("load kept tx_empty low"); // R9

   AST_RDRF_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(rx_re)) else $error("rx_full fell w/o read"); // R5

   AST_RX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(xfer_sel)) else $error("reception while deselected"); // R2

endmodule

bind spi_slave_sticky spis_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_we      (tx_we),
   .rx_re      (rx_re),
   .stat_re    (stat_re),
   .tx_empty   (tx_empty),
   .rx_full    (rx_full),
   .ovr_flag   (ovr_flag),
   .und_flag   (und_flag),
   .xfer_sel   (xfer_sel),
   .xfer_start (xfer_start)
);

// File: tb/tb_spi_slave_sticky.sv
module tb_spi_slave_sticky;

   localparam int H = 10;   // system clocks per serial half period

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  cfg_len;
   logic        cfg_cpol, cfg_ncpha;
   logic        spi_sck, spi_nss, spi_mosi;
   logic        spi_miso;
   logic        tx_we;
   logic [15:0] tx_data;
   logic        tx_empty;
   logic        rx_re, rx_re_mon, rx_re_man;
   logic [15:0] rx_data;
   logic        rx_full;
   logic        stat_re;
   logic        ovr_flag, und_flag;

   always #10 clk = ~clk;   // 50 MHz

   assign rx_re = rx_re_mon | rx_re_man;

   spi_slave_sticky dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_len   (cfg_len),
      .cfg_cpol  (cfg_cpol),
      .cfg_ncpha (cfg_ncpha),
      .spi_sck   (spi_sck),
      .spi_nss   (spi_nss),
      .spi_mosi  (spi_mosi),
      .spi_miso  (spi_miso),
      .tx_we     (tx_we),
      .tx_data   (tx_data),
      .tx_empty  (tx_empty),
      .rx_re     (rx_re),
      .rx_data   (rx_data),
      .rx_full   (rx_full),
      .stat_re   (stat_re),
      .ovr_flag  (ovr_flag),
      .und_flag  (und_flag)
   );

   int  n_chk = 0;
   int  n_err = 0;
   bit  finished = 0;
   bit  auto_read = 1;
   logic [15:0] exp_q[$];

   // requirement-level model of the transmit side
   logic [15:0] m_sreg = '0;
   logic [15:0] m_tdr = '0;
   bit m_written = 0, m_fresh = 0, m_primed = 0, m_und = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [3:0] code);
      return (code > 4'd8) ? 16 : 8 + int'(code);
   endfunction

   task automatic set_mode(input logic cpol, input logic ncpha, input logic [3:0] code);
      @(negedge clk);
      cfg_cpol  = cpol;
      cfg_ncpha = ncpha;
      cfg_len   = code;
      spi_sck   = cpol;
      repeat (8) @(negedge clk);
   endtask

   task automatic tx_write(input logic [15:0] v);
      @(negedge clk);
      tx_we   = 1'b1;
      tx_data = v;
      @(negedge clk);
      tx_we   = 1'b0;
      m_tdr   = v;
      if (!m_written) begin
         m_written = 1;
         m_sreg    = v;
         m_primed  = 1;
      end else begin
         m_fresh = 1;
      end
   endtask

   task automatic stat_pulse();
      @(negedge clk);
      stat_re = 1'b1;
      @(negedge clk);
      stat_re = 1'b0;
      m_und   = 0;
      @(negedge clk);
   endtask

   // driver: one character as the master, expected reception queued
   task automatic xfer(input logic [15:0] mo, input string req);
      int          L;
      logic [15:0] mask, send, got;
      L    = len_of(cfg_len);
      mask = (L == 16) ? 16'hFFFF : ((16'h1 << L) - 16'h1);
      got  = '0;
      if (!m_written) begin
         send = m_sreg;
      end else if (m_fresh) begin
         send = m_tdr; m_fresh = 0; m_primed = 0;
      end else if (m_primed) begin
         send = m_sreg; m_primed = 0;
      end else begin
         send = m_tdr; m_und = 1;
      end
      if (auto_read) exp_q.push_back(mo & mask);
      spi_nss = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = L - 1; i >= 0; i--) begin
         if (cfg_ncpha) begin
            spi_mosi = mo[i];
            repeat (H) @(negedge clk);
            got = {got[14:0], spi_miso};
            spi_sck = ~cfg_cpol;
            repeat (H) @(negedge clk);
            spi_sck = cfg_cpol;
         end else begin
            spi_sck  = ~cfg_cpol;
            spi_mosi = mo[i];
            repeat (H) @(negedge clk);
            got = {got[14:0], spi_miso};
            spi_sck = cfg_cpol;
            repeat (H) @(negedge clk);
         end
      end
      repeat (H) @(negedge clk);
      spi_nss = 1'b1;
      repeat (8) @(negedge clk);
      m_sreg = mo & mask;
      chk(req, got, send & mask);
   endtask

   // monitor: pops expected receptions as rx_full appears
   initial begin
      logic [15:0] e;
      rx_re_mon = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n === 1'b1 && auto_read && rx_full) begin
            if (exp_q.size() == 0) begin
               chk("R5 unexpected reception", rx_data, 32'hFFFF_FFFF);
            end else begin
               e = exp_q.pop_front();
               chk("R5 R3 received word", rx_data, e);
            end
            rx_re_mon = 1'b1;
            @(negedge clk);
            rx_re_mon = 1'b0;
            @(negedge clk);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_len = '0; cfg_cpol = 1'b0; cfg_ncpha = 1'b1;
      spi_sck = 1'b0; spi_nss = 1'b1; spi_mosi = 1'b0;
      tx_we = 1'b0; tx_data = '0; rx_re_man = 1'b0; stat_re = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk("R1 rx_full", rx_full, 0);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 ovr_flag", ovr_flag, 0);
      chk("R1 und_flag", und_flag, 0);

      set_mode(1'b0, 1'b1, 4'd0);
      xfer(16'h00A5, "R1 all-zero first reply");
      xfer(16'h003C, "R7 echo of last received");

      // R2 clocking while deselected
      for (int k = 0; k < 16; k++) begin
         spi_sck  = ~spi_sck;
         spi_mosi = ~spi_mosi;
         repeat (H) @(negedge clk);
      end
      repeat (8) @(negedge clk);
      chk("R2 no reception while deselected", rx_full, 0);
      chk("R2 queue drained", exp_q.size(), 0);
      xfer(16'h00C3, "R2 R7 aligned echo after idle clocks");

      // R8 first write loads at once
      tx_write(16'h005A);
      chk("R8 tx_empty stays high", tx_empty, 1);
      xfer(16'h000F, "R8 first write sent");
      chk("R8 no underrun", und_flag, 0);

      // R10 stale resend
      xfer(16'h00F0, "R10 stale value resent");
      chk("R10 underrun set", und_flag, 1);
      stat_pulse();
      chk("R6 status read clears underrun", und_flag, 0);

      // R9 overwriting pending writes
      tx_write(16'h0011);
      tx_write(16'h0022);
      chk("R9 tx_empty low while pending", tx_empty, 0);
      xfer(16'h0099, "R9 latest write sent");
      chk("R9 tx_empty after load", tx_empty, 1);
      chk("R9 no underrun", und_flag, 0);

      // R4 R3 all polarity/phase settings and lengths
      set_mode(1'b1, 1'b1, 4'd4);
      tx_write(16'h0ABC);
      xfer(16'h05A3, "R4 R3 cpol1 ncpha1 len12");
      set_mode(1'b0, 1'b0, 4'd8);
      tx_write(16'hBEEF);
      xfer(16'h1234, "R4 R3 cpol0 ncpha0 len16");
      set_mode(1'b1, 1'b0, 4'd15);
      tx_write(16'h8001);
      xfer(16'hC00C, "R4 R3 cpol1 ncpha0 clamped len16");
      set_mode(1'b0, 1'b1, 4'd1);
      tx_write(16'h0155);
      xfer(16'hFEAA, "R4 R3 cpol0 ncpha1 len9");
      chk("R4 no underrun across modes", und_flag, 0);

      // R6 overrun
      set_mode(1'b0, 1'b1, 4'd0);
      repeat (6) @(negedge clk);
      auto_read = 0;
      tx_write(16'h0077);
      xfer(16'h0011, "R6 first unread reply");
      chk("R5 rx_full after character", rx_full, 1);
      chk("R6 no overrun yet", ovr_flag, 0);
      tx_write(16'h0066);
      xfer(16'h0022, "R6 second unread reply");
      chk("R6 overrun set", ovr_flag, 1);
      chk("R6 newest word kept", rx_data, 16'h0022);
      stat_pulse();
      chk("R6 status read clears overrun", ovr_flag, 0);
      chk("R6 rx_full unchanged by status read", rx_full, 1);
      @(negedge clk);
      rx_re_man = 1'b1;
      @(negedge clk);
      rx_re_man = 1'b0;
      @(negedge clk);
      chk("R5 read clears rx_full", rx_full, 0);
      auto_read = 1;

      repeat (20) @(negedge clk);
      chk("R5 all receptions seen", exp_q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule